// File: doc/BRIEF.md
# Index-Register Memory Transfer Sequencer

This block owns a 12-bit index register and runs multi-cycle transfers between a small register file (16 entries of 8 bits) and a 4096-byte memory. It supports four operations, selected by a 2-bit code on a start strobe: write the three decimal digits of one register, save a run of registers starting at register 0, restore such a run, and add a register to the index. The register file and memory stay outside the block. The sequencer reads and writes them through plain synchronous ports.

Each operation makes at most one memory access per clock. The block is busy while an operation runs and pulses done once when it finishes. A surrounding execution unit sets the index through a load port, issues an operation, and waits for done. Save and restore bursts leave the index just past the block they moved. The digit operation does not touch the index.

Top module: `idx_xfer_seq`

## Requirements
- R1: Op code 0 (digits) writes the hundreds, tens and units digits of register x to addresses I, I+1 and I+2, in that order. Each digit sits in bits 3:0 and the upper bits are zero.
- R2: Op code 0 leaves I unchanged.
- R3: Op code 1 (save) writes registers 0 to x inclusive to consecutive addresses starting at I, then sets I to I+x+1.
- R4: Op code 2 (restore) reads consecutive addresses starting at I. The byte returned one cycle after each read goes into registers 0 to x inclusive, in order. It then sets I to I+x+1.
- R5: Op code 3 (add) sets I to I plus register x, modulo 4096.
- R6: All addresses and index results are 12 bits wide and wrap from 0xFFF to 0x000, including inside a burst.
- R7: At most one memory access (read or write) happens per cycle. No memory access happens while the block is idle.
- R8: done_o is a single-cycle pulse, with busy_o low, in the cycle after the last transfer. Cycles from the start edge to done are 4 for digits, x+2 for save, x+3 for restore and 2 for add.
- R9: A start strobe that arrives while busy is ignored. It causes no extra access, no index change and no later operation.
- R10: idx_set_i loads I from idx_val_i when the block is idle and is ignored while busy. I resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 2 | Operation code (0 digits, 1 save, 2 restore, 3 add) |
| x_i | input | 4 | Register index x |
| idx_set_i | input | 1 | Load the index register |
| idx_val_i | input | 12 | Value for the index register |
| idx_o | output | 12 | Current index register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_raddr_o | output | 4 | Register file read address |
| rf_rdata_i | input | 8 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write address |
| rf_wdata_o | output | 8 | Register file write data |
| mem_addr_o | output | 12 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after mem_re_o |

## Verification
The bench drives several kinds of case.
- Digit values 255, 137 and 7 exercise every decimal correction step; a faulty correction shows up as a wrong tens or hundreds digit.
- Bursts of length 1 and 16 are run; an off-by-one count would write or read one byte too many or too few.
- Bursts and an add are placed across address 0xFFF; a carry that leaks past 12 bits would produce a wrong address or index.
- Restore is checked against the one-cycle read latency; writing back from the wrong cycle would store stale bytes into the wrong registers.
- An add strobe and an index load are injected in the middle of a save; a design that accepted either would change the final index or start a second operation.

// File: rtl/idx_xfer_pkg.sv
package idx_xfer_pkg;
  typedef enum logic [1:0] {
    OP_BCD   = 2'd0,
    OP_STORE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_ADDI  = 2'd3
  } xfer_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BCD,
    ST_STORE,
    ST_LOAD,
    ST_TAIL,
    ST_ADDI
  } seq_state_e;
endpackage

// File: rtl/idx_bcd_split.sv
module idx_bcd_split #(
  parameter int DW = 8,
  parameter int ND = 3
) (
  input  logic [DW-1:0]   bin_i,
  output logic [ND*4-1:0] bcd_o
);
  // shift-and-add-3 conversion, one stage per input bit
  function automatic logic [ND*4-1:0] to_bcd(input logic [DW-1:0] b);
    logic [ND*4+DW-1:0] sh;
    sh = '0;
    sh[DW-1:0] = b;
    for (int i = 0; i < DW; i++) begin
      for (int d = 0; d < ND; d++) begin
        if (sh[DW+4*d +: 4] >= 4'd5) sh[DW+4*d +: 4] = sh[DW+4*d +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
    return sh[DW +: ND*4];
  endfunction

  assign bcd_o = to_bcd(bin_i);
endmodule

// File: rtl/idx_addr_add.sv
module idx_addr_add #(
  parameter int AW = 12,
  parameter int OW = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] sum_o
);
  logic [AW+OW-1:0] full;
  assign full  = (AW+OW)'(base_i) + (AW+OW)'(off_i);
  assign sum_o = full[AW-1:0];  // modulo 2^AW
endmodule

// File: rtl/idx_xfer_seq.sv
module idx_xfer_seq
  import idx_xfer_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 12,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [RW-1:0] x_i,
  input  logic          idx_set_i,
  input  logic [AW-1:0] idx_val_i,
  output logic [AW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int ND   = (DW * 30103) / 100000 + 1;
  localparam int OFFW = (DW > RW + 1) ? DW : RW + 1;

  seq_state_e    state_q;
  logic [RW-1:0] x_q, cnt_q, wb_idx_q;
  logic [AW-1:0] idx_q, acc_addr, idx_upd;
  logic          done_q, wb_vld_q;
  logic [ND*4-1:0] bcd;
  logic [3:0]      dig_sel;
  logic [OFFW-1:0] upd_off;
  logic            cnt_last;

  idx_bcd_split #(.DW(DW), .ND(ND)) u_bcd (
    .bin_i (rf_rdata_i),
    .bcd_o (bcd)
  );

  idx_addr_add #(.AW(AW), .OW(RW)) u_acc_add (
    .base_i (idx_q),
    .off_i  (cnt_q),
    .sum_o  (acc_addr)
  );

  idx_addr_add #(.AW(AW), .OW(OFFW)) u_upd_add (
    .base_i (idx_q),
    .off_i  (upd_off),
    .sum_o  (idx_upd)
  );

  assign upd_off  = (state_q == ST_ADDI) ? OFFW'(rf_rdata_i) : OFFW'(x_q) + OFFW'(1);
  assign cnt_last = (cnt_q == x_q);

  // most significant digit first
  always_comb begin
    dig_sel = '0;
    for (int d = 0; d < ND; d++) begin
      if (cnt_q == RW'(d)) dig_sel = bcd[4*(ND-1-d) +: 4];
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_wdata_o = '0;
    rf_raddr_o  = x_q;
    unique case (state_q)
      ST_BCD: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = DW'(dig_sel);
      end
      ST_STORE: begin
        mem_we_o    = 1'b1;
        rf_raddr_o  = cnt_q;
        mem_wdata_o = rf_rdata_i;
      end
      ST_LOAD: mem_re_o = 1'b1;
      default: ;
    endcase
  end

  assign mem_addr_o = acc_addr;
  assign rf_we_o    = wb_vld_q;
  assign rf_waddr_o = wb_idx_q;
  assign rf_wdata_o = mem_rdata_i;
  assign idx_o      = idx_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      x_q      <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      wb_vld_q <= 1'b0;
      wb_idx_q <= '0;
    end else begin
      done_q   <= 1'b0;
      wb_vld_q <= (state_q == ST_LOAD);
      wb_idx_q <= cnt_q;
      unique case (state_q)
        ST_IDLE: begin
          if (idx_set_i) idx_q <= idx_val_i;
          if (start_i) begin
            x_q   <= x_i;
            cnt_q <= '0;
            unique case (xfer_op_e'(op_i))
              OP_BCD:   state_q <= ST_BCD;
              OP_STORE: state_q <= ST_STORE;
              OP_LOAD:  state_q <= ST_LOAD;
              default:  state_q <= ST_ADDI;
            endcase
          end
        end
        ST_BCD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == RW'(ND-1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_STORE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_last) begin
            state_q <= ST_IDLE;
            idx_q   <= idx_upd;
            done_q  <= 1'b1;
          end
        end
        ST_LOAD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_last) state_q <= ST_TAIL;
        end
        ST_TAIL, ST_ADDI: begin
          state_q <= ST_IDLE;
          idx_q   <= idx_upd;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_xfer_seq_chk.sv
module idx_xfer_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] idx_o,
  input logic          idx_set_i,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o
);
  logic          vld_q, prev_acc_q, prev_set_q;
  logic [AW-1:0] prev_addr_q, prev_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q       <= 1'b0;
      prev_acc_q  <= 1'b0;
      prev_set_q  <= 1'b0;
      prev_addr_q <= '0;
      prev_idx_q  <= '0;
    end else begin
      vld_q       <= 1'b1;
      prev_acc_q  <= mem_we_o | mem_re_o;
      prev_set_q  <= idx_set_i & ~busy_o;
      prev_addr_q <= mem_addr_o;
      prev_idx_q  <= idx_o;
    end
  end

  a_r7_single_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r7_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || mem_re_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_acc_q && (mem_we_o || mem_re_o)) |-> (mem_addr_o == prev_addr_q + AW'(1)));

  a_r2_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !done_o && !prev_set_q) |-> (idx_o == prev_idx_q));
endmodule

bind idx_xfer_seq idx_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .idx_o      (idx_o),
  .idx_set_i  (idx_set_i),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/idx_xfer_seq_tb_top.sv
module idx_xfer_seq_tb_top;
  import idx_xfer_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [3:0]  x_i = 4'd0;
  logic        idx_set_i = 1'b0;
  logic [11:0] idx_val_i = '0;
  logic [11:0] idx_o, mem_addr_o;
  logic        busy_o, done_o, rf_we_o, mem_we_o, mem_re_o;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [7:0]  rf_rdata_i, rf_wdata_o, mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;

  logic [7:0] mem [4096];
  logic [7:0] rf  [16];
  logic [11:0] idx_m = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [19:0] exp_wr_q [$];  // {addr, data}
  logic [11:0] exp_rd_q [$];
  logic [11:0] exp_rf_q [$];  // {reg, data}

  always #10 clk_i = ~clk_i;

  idx_xfer_seq dut_i (
    .clk_i, .rst_ni, .start_i, .op_i, .x_i, .idx_set_i, .idx_val_i, .idx_o,
    .busy_o, .done_o, .rf_raddr_o, .rf_rdata_i, .rf_we_o, .rf_waddr_o, .rf_wdata_o,
    .mem_addr_o, .mem_we_o, .mem_wdata_o, .mem_re_o, .mem_rdata_i
  );

  assign rf_rdata_i = rf[rf_raddr_o];

  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
    if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected items as the design produces them
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_we_o) begin
        if (exp_wr_q.size() == 0) chk(0, "R7 unexpected write", int'(mem_addr_o), 0);
        else begin
          logic [19:0] e;
          e = exp_wr_q.pop_front();
          chk({mem_addr_o, mem_wdata_o} == e, "R1/R3/R6 write", int'({mem_addr_o, mem_wdata_o}), int'(e));
        end
      end
      if (mem_re_o) begin
        if (exp_rd_q.size() == 0) chk(0, "R7 unexpected read", int'(mem_addr_o), 0);
        else begin
          logic [11:0] e;
          e = exp_rd_q.pop_front();
          chk(mem_addr_o == e, "R4/R6 read address", int'(mem_addr_o), int'(e));
        end
      end
      if (rf_we_o) begin
        if (exp_rf_q.size() == 0) chk(0, "R4 unexpected reg write", int'(rf_waddr_o), 0);
        else begin
          logic [11:0] e;
          e = exp_rf_q.pop_front();
          chk({rf_waddr_o, rf_wdata_o} == e, "R4 reg write", int'({rf_waddr_o, rf_wdata_o}), int'(e));
        end
      end
    end
  end

  task automatic set_idx(input logic [11:0] v);
    idx_set_i = 1'b1;
    idx_val_i = v;
    @(negedge clk_i);
    idx_set_i = 1'b0;
    idx_m = v;
    chk(idx_o == v, "R10 index load", int'(idx_o), int'(v));
  endtask

  // driver: queue expectations, strobe, time the completion
  task automatic run_op(input logic [1:0] code, input int x, input int poke, input string req);
    int lat, exp_lat;
    logic [11:0] a;
    case (code)
      OP_BCD: begin
        int v;
        v = int'(rf[x]);
        exp_wr_q.push_back({idx_m, 8'(v / 100)});
        exp_wr_q.push_back({idx_m + 12'd1, 8'((v / 10) % 10)});
        exp_wr_q.push_back({idx_m + 12'd2, 8'(v % 10)});
        exp_lat = 4;
      end
      OP_STORE: begin
        for (int k = 0; k <= x; k++) begin
          a = idx_m + 12'(k);
          exp_wr_q.push_back({a, rf[k]});
        end
        idx_m = idx_m + 12'(x + 1);
        exp_lat = x + 2;
      end
      OP_LOAD: begin
        for (int k = 0; k <= x; k++) begin
          a = idx_m + 12'(k);
          exp_rd_q.push_back(a);
          exp_rf_q.push_back({4'(k), mem[a]});
        end
        idx_m = idx_m + 12'(x + 1);
        exp_lat = x + 3;
      end
      default: begin
        idx_m = idx_m + 12'(rf[x]);
        exp_lat = 2;
      end
    endcase
    op_i = code;
    x_i = 4'(x);
    start_i = 1'b1;
    lat = 0;
    while (!(lat > 0 && done_o) && lat < 64) begin
      @(negedge clk_i);
      lat++;
      start_i = 1'b0;
      idx_set_i = 1'b0;
      if (lat == poke) begin
        start_i = 1'b1;
        op_i = OP_ADDI;
        x_i = 4'd5;
        idx_set_i = 1'b1;
        idx_val_i = 12'hABC;
      end
    end
    chk(lat == exp_lat, {req, " R8 latency"}, lat, exp_lat);
    chk(idx_o == idx_m, {req, " index result"}, int'(idx_o), int'(idx_m));
    chk(!busy_o, {req, " R8 idle at done"}, int'(busy_o), 0);
    @(negedge clk_i);
    chk(!done_o, {req, " R8 done single pulse"}, int'(done_o), 0);
    chk(exp_wr_q.size() + exp_rd_q.size() + exp_rf_q.size() == 0, {req, " all transfers seen"},
        exp_wr_q.size() + exp_rd_q.size() + exp_rf_q.size(), 0);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 7 + 1) ^ (a >> 4));
    for (int k = 0; k < 16; k++) rf[k] = 8'(k * 19 + 4);
    rf[5] = 8'd255;
    rf[6] = 8'd137;
    rf[7] = 8'd7;
    rf[8] = 8'd0;
    repeat (3) @(negedge clk_i);
    chk(idx_o == 12'h000, "R10 reset index", int'(idx_o), 0);
    chk(!busy_o && !done_o, "R8 reset idle", int'({busy_o, done_o}), 0);
    chk(!mem_we_o && !mem_re_o && !rf_we_o, "R7 reset quiet", int'({mem_we_o, mem_re_o, rf_we_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    set_idx(12'h300);
    run_op(OP_BCD, 5, 0, "R1 R2 digits 255");
    run_op(OP_BCD, 6, 0, "R1 R2 digits 137");
    run_op(OP_BCD, 7, 0, "R1 R2 digits 7");
    run_op(OP_BCD, 8, 0, "R1 R2 digits 0");
    run_op(OP_STORE, 3, 0, "R3 save x=3");
    run_op(OP_STORE, 15, 0, "R3 save x=15");
    set_idx(12'h800);
    run_op(OP_LOAD, 0, 0, "R4 restore x=0");
    run_op(OP_LOAD, 7, 0, "R4 restore x=7");
    run_op(OP_ADDI, 5, 0, "R5 add");
    set_idx(12'hFFE);
    run_op(OP_STORE, 3, 0, "R6 save wrap");
    chk(idx_o == 12'h002, "R6 index after wrap", int'(idx_o), 2);
    set_idx(12'hFFD);
    run_op(OP_LOAD, 4, 0, "R6 restore wrap");
    set_idx(12'hFF0);
    rf[9] = 8'h20;
    run_op(OP_ADDI, 9, 0, "R5 R6 add wrap");
    chk(idx_o == 12'h010, "R6 add wrap value", int'(idx_o), 16);
    set_idx(12'h100);
    run_op(OP_STORE, 4, 2, "R9 R10 strobe while busy");
    repeat (3) begin
      @(negedge clk_i);
      chk(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R9 no late operation",
          int'({busy_o, done_o, mem_we_o, mem_re_o}), 0);
    end
    chk(idx_o == 12'h105, "R9 index untouched by ignored strobe", int'(idx_o), 12'h105);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule